// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the architectural state of an eight-entry floating-point register stack. It holds the data registers and a 16-bit control word. It also holds a 16-bit status word carrying a 3-bit top-of-stack pointer, a 16-bit tag word with two bits per physical register, and the captured instruction and data pointers. Each clock it can take one command: initialize, push, pop, advance the stack pointer, or release an entry. A push writes either new data or a copy of a stack-relative entry.

Stack faults are reported in the status word. Overflow and underflow both set the invalid-operation and stack-fault flags. Condition bit C1 then tells them apart: 1 for overflow, 0 for underflow. A combinational read port maps a stack-relative index to its physical register and returns that register's data and tag. Arithmetic, memory traffic and trap delivery belong to other units.

Top module: `fpstk_ctrl`

## Requirements
- R1: After an initialize command (cmd_op=1), ctrl_word reads 16'h037F: rounding to nearest, extended precision, and all six exception masks set.
- R2: After an initialize command, status_word reads zero, so TOP (status_word[13:11]) is 0 and ST(0) maps to physical register 0.
- R3: After an initialize command, every tag field reads 11b (empty); tag_word[2k+1:2k] holds the tag of physical register k, with 00b meaning valid.
- R4: An initialize command clears ip_out and dp_out and leaves the contents of every data register unchanged.
- R5: A push (cmd_op=2) whose target (TOP-1 mod 8) is empty decrements TOP mod 8, writes the data there with tag 00b, and clears C1 (status_word[9]). Push and pop both capture ip_in and dp_in into ip_out and dp_out.
- R6: A push whose target is not empty is an overflow. It sets C1, IE (status_word[0]) and SF (status_word[6]), and leaves TOP, tags and data unchanged.
- R7: With push_copy=1, a push writes the value of ST(cmd_idx) as read before the push. If that source is empty, the push is an underflow: IE and SF are set, C1 is cleared, and nothing else changes.
- R8: A pop (cmd_op=3) marks the top entry empty, increments TOP mod 8 and clears C1. If the top entry was already empty, IE and SF are also set.
- R9: An advance command (cmd_op=4) adds 1 to TOP mod 8 and changes no tag.
- R10: A release command (cmd_op=5) marks ST(cmd_idx) empty and leaves TOP unchanged.
- R11: rd_data and rd_tag show physical register (TOP + rd_idx) mod 8 in the same cycle.
- R12: Reset produces the initialized state with all data registers zero. IE and SF stay set once set, until the next initialize or reset. A no-op (cmd_op=0) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 initialize, 2 push, 3 pop, 4 advance, 5 release |
| cmd_idx | input | 3 | Stack-relative index for copy-push and release |
| push_copy | input | 1 | Push takes ST(cmd_idx) instead of wr_data |
| wr_data | input | DATA_W | Push data |
| ip_in | input | PTR_W | Instruction pointer captured on push and pop |
| dp_in | input | PTR_W | Data pointer captured on push and pop |
| rd_idx | input | 3 | Stack-relative read index |
| rd_data | output | DATA_W | Data of ST(rd_idx) |
| rd_tag | output | 2 | Tag of ST(rd_idx) |
| ctrl_word | output | 16 | Control word |
| status_word | output | 16 | Status word (IE bit 0, SF bit 6, C1 bit 9, TOP bits 13:11) |
| tag_word | output | 16 | Two tag bits per physical register |
| ip_out | output | PTR_W | Captured instruction pointer |
| dp_out | output | PTR_W | Captured data pointer |

## Verification
The bench fills the stack until a ninth push overflows. A design that let the overflow through would decrement TOP or overwrite register data, and the model would see the mismatch. It pops past the bottom to force underflow, where a wrong C1 polarity or a missing sticky flag shows up at once. It also pushes a copy of an empty entry, and initializes a full stack and then reads the old data back, which catches an initialize that wipes the registers. A long random command stream then walks TOP through every wrap. An off-by-one in the relative-to-physical mapping would show up there as wrong read data.

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl #(
  parameter int DATA_W = 80,
  parameter int NREG   = 8,
  parameter int PTR_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [2:0]        cmd_idx,
  input  logic              push_copy,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  ip_in,
  input  logic [PTR_W-1:0]  dp_in,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_tag,
  output logic [15:0]       ctrl_word,
  output logic [15:0]       status_word,
  output logic [15:0]       tag_word,
  output logic [PTR_W-1:0]  ip_out,
  output logic [PTR_W-1:0]  dp_out
);
  localparam int IW = $clog2(NREG);
  localparam logic [2:0] OP_INIT = 3'd1, OP_PUSH = 3'd2, OP_POP = 3'd3,
                         OP_INC = 3'd4, OP_FREE = 3'd5;
  localparam logic [1:0] T_VALID = 2'b00, T_EMPTY = 2'b11;
  localparam logic [15:0] CW_INIT = 16'h037F;

  logic [DATA_W-1:0] regs [NREG];
  logic [1:0]        tags [NREG];
  logic [IW-1:0]     top;
  logic [15:0]       cw;
  logic              ie, sf, c1;

  wire [IW-1:0] new_top  = top - 1'b1;
  wire [IW-1:0] src_phys = top + cmd_idx;
  wire [IW-1:0] rd_phys  = top + rd_idx;
  wire          ovf      = tags[new_top] != T_EMPTY;
  wire          src_unf  = push_copy && (tags[src_phys] == T_EMPTY);
  wire          pop_unf  = tags[top] == T_EMPTY;
  wire [DATA_W-1:0] push_val = push_copy ? regs[src_phys] : wr_data;

  assign rd_data     = regs[rd_phys];
  assign rd_tag      = tags[rd_phys];
  assign ctrl_word   = cw;
  assign status_word = {2'b00, top, 1'b0, c1, 2'b00, sf, 5'b00000, ie};

  for (genvar k = 0; k < NREG; k++) begin : g_tag
    assign tag_word[2*k +: 2] = tags[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        regs[k] <= '0;
        tags[k] <= T_EMPTY;
      end
      top <= '0; cw <= CW_INIT; ie <= 1'b0; sf <= 1'b0; c1 <= 1'b0;
      ip_out <= '0; dp_out <= '0;
    end else begin
      case (cmd_op)
        OP_INIT: begin
          for (int k = 0; k < NREG; k++) tags[k] <= T_EMPTY;
          top <= '0; cw <= CW_INIT; ie <= 1'b0; sf <= 1'b0; c1 <= 1'b0;
          ip_out <= '0; dp_out <= '0;
        end
        OP_PUSH: begin
          ip_out <= ip_in; dp_out <= dp_in;
          if (src_unf) begin
            ie <= 1'b1; sf <= 1'b1; c1 <= 1'b0;
          end else if (ovf) begin
            ie <= 1'b1; sf <= 1'b1; c1 <= 1'b1;
          end else begin
            regs[new_top] <= push_val;
            tags[new_top] <= T_VALID;
            top <= new_top;
            c1 <= 1'b0;
          end
        end
        OP_POP: begin
          ip_out <= ip_in; dp_out <= dp_in;
          if (pop_unf) begin
            ie <= 1'b1; sf <= 1'b1;
          end
          c1 <= 1'b0;
          tags[top] <= T_EMPTY;
          top <= top + 1'b1;
        end
        OP_INC:  top <= top + 1'b1;
        OP_FREE: tags[src_phys] <= T_EMPTY;
        default: ;
      endcase
    end
  end

  AST_INIT_CW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_INIT |=> ctrl_word == 16'h037F); // R1
  AST_INIT_SW: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_INIT |=> status_word == 16'h0000); // R2
  AST_INIT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_INIT |=> tag_word == 16'hFFFF); // R3
  AST_INIT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_INIT |=> (ip_out == '0 && dp_out == '0)); // R4
  AST_PUSH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_PUSH && !ovf && !src_unf) |=>
      (status_word[13:11] == 3'($past(status_word[13:11]) - 3'd1) && !status_word[9])); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_PUSH && !src_unf && ovf) |=>
      (status_word[9] && status_word[6] && status_word[0] && $stable(tag_word)
       && status_word[13:11] == $past(status_word[13:11]))); // R6
  AST_POP_C1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_POP |=> (!status_word[9] && status_word[13:11] == 3'($past(status_word[13:11]) + 3'd1))); // R8
  AST_INC_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_INC |=> $stable(tag_word)); // R9
  AST_FREE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == OP_FREE |=> $stable(status_word)); // R10
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[6] && cmd_op != OP_INIT) |=> status_word[6]); // R12
endmodule

// File: tb/fpstk_ctrl_tb.sv
module fpstk_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  cmd_op, cmd_idx, rd_idx;
  logic        push_copy;
  logic [79:0] wr_data, rd_data;
  logic [47:0] ip_in, dp_in, ip_out, dp_out;
  logic [1:0]  rd_tag;
  logic [15:0] ctrl_word, status_word, tag_word;

  fpstk_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .push_copy(push_copy), .wr_data(wr_data), .ip_in(ip_in), .dp_in(dp_in),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag), .ctrl_word(ctrl_word),
    .status_word(status_word), .tag_word(tag_word), .ip_out(ip_out), .dp_out(dp_out));

  int checks = 0, errors = 0;
  int m_top;
  logic [1:0]  m_tag [8];
  logic [79:0] m_dat [8];
  logic [15:0] m_cw;
  bit          m_ie, m_sf, m_c1;
  logic [47:0] m_ip, m_dp;

  task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [15:0] sw, tw;
    int p;
    sw = {2'b00, 3'(m_top), 1'b0, m_c1, 2'b00, m_sf, 5'b0, m_ie};
    for (int k = 0; k < 8; k++) tw[2*k +: 2] = m_tag[k];
    p = (m_top + int'(rd_idx)) % 8;
    chk(req, "ctrl_word", 80'(ctrl_word), 80'(m_cw));
    chk(req, "status_word", 80'(status_word), 80'(sw));
    chk(req, "tag_word", 80'(tag_word), 80'(tw));
    chk(req, "ip_out", 80'(ip_out), 80'(m_ip));
    chk(req, "dp_out", 80'(dp_out), 80'(m_dp));
    chk(req, "rd_tag R11", 80'(rd_tag), 80'(m_tag[p]));
    chk(req, "rd_data R11", rd_data, m_dat[p]);
  endtask

  task automatic model(logic [2:0] op, logic [2:0] idx, logic cp, logic [79:0] d,
                       logic [47:0] ipv, logic [47:0] dpv);
    int nt, src;
    nt  = (m_top + 7) % 8;
    src = (m_top + int'(idx)) % 8;
    case (op)
      3'd1: begin
        m_cw = 16'h037F; m_top = 0; m_ie = 0; m_sf = 0; m_c1 = 0; m_ip = '0; m_dp = '0;
        for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
      end
      3'd2: begin
        m_ip = ipv; m_dp = dpv;
        if (cp && m_tag[src] == 2'b11) begin m_ie = 1; m_sf = 1; m_c1 = 0; end
        else if (m_tag[nt] != 2'b11) begin m_ie = 1; m_sf = 1; m_c1 = 1; end
        else begin
          m_dat[nt] = cp ? m_dat[src] : d;
          m_tag[nt] = 2'b00; m_top = nt; m_c1 = 0;
        end
      end
      3'd3: begin
        m_ip = ipv; m_dp = dpv;
        if (m_tag[m_top] == 2'b11) begin m_ie = 1; m_sf = 1; end
        m_c1 = 0; m_tag[m_top] = 2'b11; m_top = (m_top + 1) % 8;
      end
      3'd4: m_top = (m_top + 1) % 8;
      3'd5: m_tag[src] = 2'b11;
      default: ;
    endcase
  endtask

  task automatic step(string req, logic [2:0] op, logic [2:0] idx = 3'd0,
                      logic cp = 1'b0, logic [79:0] d = '0, logic [2:0] ri = 3'd0);
    logic [47:0] ipv, dpv;
    ipv = {16'h0, $urandom}; dpv = {$urandom, 16'h1};
    cmd_op = op; cmd_idx = idx; push_copy = cp; wr_data = d; ip_in = ipv; dp_in = dpv;
    rd_idx = ri;
    model(op, idx, cp, d, ipv, dpv);
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_op = 0; cmd_idx = 0; push_copy = 0; wr_data = '0;
    ip_in = '0; dp_in = '0; rd_idx = 0;
    m_cw = 16'h037F; m_top = 0; m_ie = 0; m_sf = 0; m_c1 = 0; m_ip = '0; m_dp = '0;
    for (int k = 0; k < 8; k++) begin m_tag[k] = 2'b11; m_dat[k] = '0; end
    repeat (3) @(negedge clk);
    compare("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12 reset");
    step("R12 nop", 3'd0);
    // R5 pushes, R11 reads
    step("R5 push", 3'd2, 0, 0, 80'h1111_2222_3333_4444_5555, 3'd0);
    step("R5 push", 3'd2, 0, 0, 80'hAAAA_BBBB_CCCC_DDDD_EEEE, 3'd1);
    step("R5 push", 3'd2, 0, 0, 80'h0123_4567_89AB_CDEF_0F0F, 3'd2);
    step("R11 read", 3'd0, 0, 0, '0, 3'd1);
    step("R7 copy", 3'd2, 3'd2, 1'b1, '0, 3'd0);
    step("R7 copy empty src", 3'd2, 3'd6, 1'b1, '0, 3'd0);
    step("R9 advance", 3'd4, 0, 0, '0, 3'd7);
    step("R10 release", 3'd5, 3'd1, 0, '0, 3'd1);
    step("R1 init", 3'd1);
    for (int k = 0; k < 9; k++) step("R5 R6 fill", 3'd2, 0, 0, rnd80(), 3'(k));
    step("R6 overflow", 3'd2, 0, 0, rnd80(), 3'd0);
    step("R2 R3 R4 init keeps data", 3'd1, 0, 0, '0, 3'd5);
    step("R4 data kept", 3'd0, 0, 0, '0, 3'd3);
    step("R8 pop underflow", 3'd3, 0, 0, '0, 3'd0);
    step("R12 sticky", 3'd2, 0, 0, rnd80(), 3'd0);
    step("R8 pop", 3'd3);
    step("R8 pop underflow", 3'd3);
    step("R1 init", 3'd1);
    for (int n = 0; n < 2000; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 6);
      if (op == 3'd1 && ($urandom % 16) != 0) op = 3'd2;
      step("R5-R11 random", op, 3'($urandom), 1'($urandom), rnd80(), 3'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule